// File: doc/BRIEF.md
# One-shot interval timer channel

This block is one 16-bit down-counting timer channel that raises an interrupt once when its count runs out. A bus master loads it with byte writes: a control write puts the channel into a known idle state, and then the count goes in as two writes to the data address, low byte first. The channel counts rising edges of a count-clock input while a gate input is high. Its output goes high at terminal count and stays high, so each load gives exactly one interrupt edge.

Both the count-clock input and the bus write strobe are sampled by the system clock. The count clock must stay high or low for at least one system clock so that its rising edges can be detected. Writing the first byte halts a count that has not yet reached terminal count. Writing the second byte arms a load, and that load happens on the next count-clock edge. Once the count has passed terminal count it wraps and keeps running, and a lone first-byte write no longer halts it. The current count is brought out so the counting can be observed.

Top module: `tcTimer`

## Requirements
- R1: After reset, `irqOut` is low, `countNow` is 0000h, counting is stopped and the next data write is taken as the low byte.
- R2: A write with `wrAddr` = 2'b11 is a control write and a write with `wrAddr` = 2'b00 is a count-byte write. Writes to 2'b01 and 2'b10 change neither `irqOut` nor `countNow`.
- R3: A control write drives `irqOut` low on the next clock, stops the count, cancels a pending load and makes the next data write the low byte.
- R4: A low-byte write made before the count has reached terminal count since the last load stops the counter, and `countNow` then holds through further count-clock edges.
- R5: A low-byte write made after terminal count has been reached leaves the counter decrementing.
- R6: A high-byte write holds `countNow` until the next count-clock rising edge. On that edge `countNow` becomes {high byte, low byte}. Each later rising edge seen with `gate` high lowers it by one.
- R7: A count-clock rising edge seen with `gate` low leaves `countNow` unchanged.
- R8: `irqOut` goes high on the edge that takes `countNow` from 0001h to 0000h and stays high until a control write or a high-byte write, which drives it low on the next clock.
- R9: A decrement from 0000h gives FFFFh and counting continues, with `irqOut` unchanged.
- R10: A loaded count of 0000h reaches terminal count after 65536 decrements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples all inputs |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe, one clock per write |
| wrAddr | input | 2 | Register select: 2'b11 control, 2'b00 count data |
| wrData | input | 8 | Write data byte |
| cntClk | input | 1 | Count clock, sampled by clk, counted on rising edge |
| gate | input | 1 | Count enable, high allows decrementing |
| countNow | output | 16 | Current counter value |
| irqOut | output | 1 | Interrupt request, high from terminal count |

## Verification
Every result appears one system clock after the edge that samples its cause. A write shows on `irqOut` at the clock after the strobe. A count-clock rising edge is detected at the first clock that sees `cntClk` high, and `countNow` and `irqOut` change at that clock. The bench drives each stimulus for one clock on the falling edge, releases it at the next falling edge and samples both outputs there. It then compares them with a reference model that it steps by the same operation. The load therefore shows at the first count-clock pulse after the high byte, and terminal count for a load of N shows at pulse N+1.

// File: rtl/tcTimerPkg.sv
package tcTimerPkg;
  localparam int BYTE_W  = 8;
  localparam int COUNT_W = 2 * BYTE_W;
  localparam int ADDR_W  = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // take loadVal into the counter
    logic dec;     // decrement the counter
    logic clrOut;  // force the interrupt output low
  } tmrStrobe_t;
endpackage

// File: rtl/tcTimerCtrl.sv
module tcTimerCtrl
  import tcTimerPkg::*;
#(
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 2'b11,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 2'b00
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [BYTE_W-1:0]  wrData,
  input  logic               cntClk,
  input  logic               gate,
  input  logic               tcEvent,
  output tmrStrobe_t         strobe,
  output logic [COUNT_W-1:0] loadVal
);
  logic              cntClkQ;
  logic              bytePtrHigh;
  logic              runEn;
  logic              loadPend;
  logic              tcSeen;
  logic [BYTE_W-1:0] loLatch;
  logic              cntEdge;
  logic              ctrlWr;
  logic              dataWr;

  assign cntEdge = cntClk & ~cntClkQ;
  assign ctrlWr  = wrEn && (wrAddr == CTRL_ADDR);
  assign dataWr  = wrEn && (wrAddr == DATA_ADDR);

  always_comb begin
    strobe.load   = cntEdge && loadPend;
    strobe.dec    = cntEdge && gate && runEn && !loadPend;
    strobe.clrOut = ctrlWr || (dataWr && bytePtrHigh);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntClkQ     <= 1'b0;
      bytePtrHigh <= 1'b0;
      runEn       <= 1'b0;
      loadPend    <= 1'b0;
      tcSeen      <= 1'b0;
      loLatch     <= '0;
      loadVal     <= '0;
    end else begin
      cntClkQ <= cntClk;
      if (strobe.load) begin
        loadPend <= 1'b0;
        runEn    <= 1'b1;
      end
      if (tcEvent) tcSeen <= 1'b1;
      if (ctrlWr) begin
        bytePtrHigh <= 1'b0;
        runEn       <= 1'b0;
        loadPend    <= 1'b0;
        tcSeen      <= 1'b0;
      end else if (dataWr && !bytePtrHigh) begin
        loLatch     <= wrData;
        bytePtrHigh <= 1'b1;
        if (!tcSeen) runEn <= 1'b0;
      end else if (dataWr) begin
        loadVal     <= {wrData, loLatch};
        bytePtrHigh <= 1'b0;
        loadPend    <= 1'b1;
        runEn       <= 1'b0;
        tcSeen      <= 1'b0;
      end
    end
  end

  // R3: control write resets the byte pointer and stops counting
  p_ctrl_resets_ptr_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (!bytePtrHigh && !runEn && !loadPend));

  // R4: low byte before terminal count stops counting
  p_low_halts_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && !bytePtrHigh && !tcSeen) |=> !runEn);

  // R5: low byte after terminal count keeps counting
  p_low_keeps_run_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && !bytePtrHigh && tcSeen && runEn && !strobe.load) |=> runEn);

  // R6: a pending load completes on the next count-clock edge
  p_load_arms_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !wrEn) |=> (runEn && !loadPend));
endmodule

// File: rtl/tcTimerDatapath.sv
module tcTimerDatapath
  import tcTimerPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  tmrStrobe_t         strobe,
  input  logic [COUNT_W-1:0] loadVal,
  output logic               tcEvent,
  output logic [COUNT_W-1:0] countNow,
  output logic               irqOut
);
  localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

  assign tcEvent = strobe.dec && (countNow == ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countNow <= '0;
      irqOut   <= 1'b0;
    end else begin
      if (strobe.load)      countNow <= loadVal;
      else if (strobe.dec)  countNow <= countNow - ONE;
      if (strobe.clrOut)    irqOut <= 1'b0;
      else if (tcEvent)     irqOut <= 1'b1;
    end
  end

  // R4/R7: counter holds without a load or decrement strobe
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.dec) |=> $stable(countNow));

  // R6: load takes the assembled value
  p_load_value_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (countNow == $past(loadVal)));

  // R9: wrap from zero to all ones
  p_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dec && !strobe.load && countNow == '0) |=> (countNow == '1));

  // R8: output stays high until cleared
  p_irq_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !strobe.clrOut) |=> irqOut);

  // R8: output rises only at terminal count
  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ($past(tcEvent) && countNow == '0));

  // R3: clear strobe drives output low
  p_clr_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrOut |=> !irqOut);
endmodule

// File: rtl/tcTimer.sv
module tcTimer
  import tcTimerPkg::*;
#(
  parameter logic [1:0] CTRL_ADDR = 2'b11,
  parameter logic [1:0] DATA_ADDR = 2'b00
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [7:0]  wrData,
  input  logic        cntClk,
  input  logic        gate,
  output logic [15:0] countNow,
  output logic        irqOut
);
  tmrStrobe_t         strobe;
  logic [COUNT_W-1:0] loadVal;
  logic               tcEvent;

  tcTimerCtrl #(.CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cntClk(cntClk), .gate(gate), .tcEvent(tcEvent),
    .strobe(strobe), .loadVal(loadVal)
  );

  tcTimerDatapath i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadVal(loadVal),
    .tcEvent(tcEvent), .countNow(countNow), .irqOut(irqOut)
  );

  // R1: reset state visible at the ports
  p_reset_state_r1: assert property (@(posedge clk)
    !rstN |=> (!irqOut && countNow == '0));
endmodule

// File: tb/test_tcTimer.sv
module test_tcTimer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'b00;
  logic [7:0]  wrData = 8'h00;
  logic        cntClk = 1'b0;
  logic        gate = 1'b1;
  logic [15:0] countNow;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done = 1'b0;

  // reference model state
  logic [15:0] mCount = 16'h0;
  logic        mIrq = 1'b0, mRun = 1'b0, mPend = 1'b0, mTc = 1'b0, mPtr = 1'b0;
  logic [7:0]  mLo = 8'h0;
  logic [15:0] mLoad = 16'h0;

  always #5 clk = ~clk;

  tcTimer i_tcTimer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cntClk(cntClk), .gate(gate), .countNow(countNow), .irqOut(irqOut)
  );

  function automatic logic [15:0] decOf(input logic [15:0] v);
    return v - 16'd1;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chkBoth(input string tag);
    chk(tag, countNow, mCount, "countNow");
    chk(tag, {15'd0, irqOut}, {15'd0, mIrq}, "irqOut");
  endtask

  task automatic tick(input logic g, input string tag);
    @(negedge clk); gate = g; cntClk = 1'b1;
    @(negedge clk); cntClk = 1'b0;
    if (mPend) begin
      mCount = mLoad; mPend = 1'b0; mRun = 1'b1;
    end else if (g && mRun) begin
      if (mCount == 16'd1) begin mIrq = 1'b1; mTc = 1'b1; end
      mCount = decOf(mCount);
    end
    chkBoth(tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
    if (a == 2'b11) begin
      mIrq = 1'b0; mPtr = 1'b0; mRun = 1'b0; mPend = 1'b0; mTc = 1'b0;
    end else if (a == 2'b00) begin
      if (!mPtr) begin
        mLo = d; mPtr = 1'b1;
        if (!mTc) mRun = 1'b0;
      end else begin
        mLoad = {d, mLo}; mPtr = 1'b0; mPend = 1'b1; mRun = 1'b0; mTc = 1'b0; mIrq = 1'b0;
      end
    end
    chkBoth(tag);
  endtask

  task automatic loadCount(input logic [15:0] v, input string tag);
    wr(2'b11, 8'h30, tag);
    wr(2'b00, v[7:0], tag);
    wr(2'b00, v[15:8], tag);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240801));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkBoth("R1");

    // R6 / R8: load 5, output rises on the 6th pulse
    loadCount(16'd5, "R6");
    for (int i = 0; i < 6; i++) tick(1'b1, "R8");
    chk("R8", {15'd0, irqOut}, 16'd1, "irq after count 5");
    for (int i = 0; i < 3; i++) tick(1'b1, "R9");
    chk("R9", countNow, 16'hFFFD, "wrapped count");

    // R5: low byte after terminal count keeps counting
    wr(2'b00, 8'h07, "R5");
    tick(1'b1, "R5");
    chk("R5", countNow, 16'hFFFC, "still counting");
    wr(2'b00, 8'h00, "R6");
    tick(1'b1, "R6");
    chk("R6", countNow, 16'h0007, "reload value");

    // R4: low byte mid-count halts
    for (int i = 0; i < 3; i++) tick(1'b1, "R6");
    wr(2'b00, 8'h09, "R4");
    for (int i = 0; i < 4; i++) tick(1'b1, "R4");
    chk("R4", countNow, 16'h0004, "halted count");
    wr(2'b00, 8'h00, "R4");
    for (int i = 0; i < 10; i++) tick(1'b1, "R8");
    chk("R8", {15'd0, irqOut}, 16'd1, "irq after reload 9");

    // R7: gate low holds
    loadCount(16'd3, "R7");
    tick(1'b1, "R7");
    for (int i = 0; i < 4; i++) tick(1'b0, "R7");
    chk("R7", countNow, 16'h0003, "gate low hold");

    // R2: unused addresses ignored
    wr(2'b01, 8'hAA, "R2");
    wr(2'b10, 8'h55, "R2");
    tick(1'b1, "R2");
    chk("R2", countNow, 16'h0002, "after ignored writes");

    // R3: control write clears output and halts
    for (int i = 0; i < 2; i++) tick(1'b1, "R8");
    wr(2'b11, 8'h30, "R3");
    chk("R3", {15'd0, irqOut}, 16'd0, "irq after control");
    tick(1'b1, "R3");

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int op;
      op = $urandom_range(0, 99);
      if (op < 68)       tick(($urandom_range(0, 9) != 0), "R6");
      else if (op < 78)  wr(2'b00, 8'($urandom_range(0, 255)), "R4");
      else if (op < 86)  wr(2'b00, 8'($urandom_range(0, 1)), "R6");
      else if (op < 89)  wr(2'b11, 8'h30, "R3");
      else if (op < 91)  wr(2'($urandom_range(1, 2)), 8'hFF, "R2");
      else               loadCount(16'($urandom_range(1, 40)), "R8");
    end

    // R10: zero count means 65536
    loadCount(16'h0000, "R10");
    tick(1'b1, "R10");
    for (int i = 0; i < 65535; i++) tick(1'b1, "R10");
    chk("R10", {15'd0, irqOut}, 16'd0, "irq before last decrement");
    tick(1'b1, "R10");
    chk("R10", {15'd0, irqOut}, 16'd1, "irq at 65536");
    chk("R10", countNow, 16'h0000, "count at terminal");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule